// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 32 external interrupt lines and one non-maskable line, and it holds a pending flag for each. It presents one request to the processor core: the highest-priority line that is both pending and enabled, together with its number. Software sets an enable bit, a 2-bit priority and a sensing mode for each line through a small register port that only accepts word accesses. Each line can be captured either on its level or on its rising edge.

The core takes a request by pulsing `ack_i` while `req_valid` is high. Taking an external request clears that line's pending flag and makes its priority the single active level. After that, only a strictly more urgent request is forwarded. Pulsing `done_i` ends the active level. The non-maskable line cannot be disabled and does not depend on the active level. Register contents are little-endian: bit n of a mask word, or byte n of a priority word, belongs to the lower-numbered line. The inputs are assumed to be synchronous to `clk`.

Top module: `prio_intc`

## Requirements
- R1: After reset, every line is disabled, not pending, level-sensed and at priority 0, no level is active, and `req_valid`, `req_nmi` and `req_id` are all zero.
- R2: A word write to 0x00 sets the enable bits written as 1, and a word write to 0x04 clears them. A word read of either address returns the enable mask, with bit n belonging to line n.
- R3: A word write to 0x08 sets the pending bits written as 1, and a word write to 0x0C clears them. A word read of either address returns the pending mask. A set and a clear of the same line in the same cycle leave the line pending.
- R4: A level-sensed line (bit 0 in the sense register at 0x10) becomes pending in every cycle its input is high. It therefore stays pending after being acknowledged or cleared while its input is high, and it stays pending after the input falls until it is acknowledged or cleared.
- R5: A pulse-sensed line (bit 1 at 0x10) becomes pending only on a rising edge of its input. It stays pending after the input falls, until it is acknowledged or cleared. A steady high input does not pend it again.
- R6: The priority of line n lives in word 0x20 + 4*(n/4), in bits [1:0] of byte n%4. The other bits of each byte read as zero, and unmapped word addresses read as zero.
- R7: Among lines that are both pending and enabled, the one with the lowest priority value is chosen, and ties go to the lower line number. `req_id` carries that number while it is forwarded and is 0 otherwise.
- R8: An external request is forwarded only when no level is active or its priority value is strictly below the active one. An acknowledge of an external request clears that line's pending flag and makes its priority the active level. `done_i` drops the active level, unless an external acknowledge happens in the same cycle, which wins.
- R9: A rising edge on `nmi_i` pends the non-maskable request. It is then forwarded ahead of every external line, with `req_nmi` = 1 and `req_id` = 0, whatever the enables and the active level. An acknowledge clears it and leaves the active level unchanged.
- R10: A write whose `bus_size` is not 2 (word) or whose address is not word-aligned changes nothing. A read of that kind returns zero.
- R11: A pending line that is disabled is shown in the pending mask but is not requested. Enabling it later forwards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | External interrupt lines |
| nmi_i | input | 1 | Non-maskable interrupt line |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| req_valid | output | 1 | A request is presented to the core |
| req_nmi | output | 1 | The request is the non-maskable one |
| req_id | output | ID_W | Number of the forwarded external line |
| ack_i | input | 1 | Core takes the presented request |
| done_i | input | 1 | Core leaves the active level |

## Verification
Directed sequences check each behaviour on its own:
- Equal-priority ties show whether the lower number wins.
- A pulse followed by a low input separates edge capture from level capture.
- A level line held high across an acknowledge shows whether it pends again.
- Same-level and more-urgent lines pended under an active level show whether the threshold comparison is strict.

Narrow and misaligned accesses aimed at the enable register show whether the size and alignment filter works. A long run of random line toggles, acknowledges, done pulses and register accesses of every size is then compared cycle by cycle with a model written from the requirements. This catches interactions between capture, selection and the threshold that the directed cases miss.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_size,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               req_valid,
  output logic               req_nmi,
  output logic [ID_W-1:0]    req_id,
  input  logic               ack_i,
  input  logic               done_i
);
  logic [NUM_IRQ-1:0] en_q, pend_q, sense_q, irq_q;
  logic [PRIO_W-1:0]  prio_q [NUM_IRQ];
  logic               nmi_q, nmi_pend_q, act_v_q;
  logic [PRIO_W-1:0]  act_p_q;

  wire       word_ok = (bus_size == 2'd2) && (bus_addr[1:0] == 2'd0);
  wire       wr_ok   = bus_sel && bus_wr && word_ok;
  wire       rd_ok   = bus_sel && !bus_wr && word_ok;
  wire [5:0] widx    = bus_addr[7:2];
  wire [NUM_IRQ-1:0] wmask = bus_wdata[NUM_IRQ-1:0];

  logic              found;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    found   = 1'b0;
    best_id = '0;
    best_p  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (en_q[i] && pend_q[i] && (!found || prio_q[i] < best_p)) begin
        found   = 1'b1;
        best_id = ID_W'(i);
        best_p  = prio_q[i];
      end
    end
  end

  wire ext_fwd = found && (!act_v_q || best_p < act_p_q);
  wire ack_ext = ack_i && ext_fwd && !nmi_pend_q;

  assign req_nmi   = nmi_pend_q;
  assign req_valid = nmi_pend_q || ext_fwd;
  assign req_id    = (ext_fwd && !nmi_pend_q) ? best_id : '0;

  wire [NUM_IRQ-1:0] pend_set = (~sense_q & irq_i) | (sense_q & irq_i & ~irq_q)
                              | ((wr_ok && widx == 6'd2) ? wmask : '0);
  wire [NUM_IRQ-1:0] pend_clr = (ack_ext ? (NUM_IRQ'(1) << best_id) : '0)
                              | ((wr_ok && widx == 6'd3) ? wmask : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      pend_q     <= '0;
      sense_q    <= '0;
      irq_q      <= '0;
      nmi_q      <= 1'b0;
      nmi_pend_q <= 1'b0;
      act_v_q    <= 1'b0;
      act_p_q    <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
    end else begin
      irq_q  <= irq_i;
      nmi_q  <= nmi_i;
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      if (wr_ok && widx == 6'd0) en_q <= en_q | wmask;
      if (wr_ok && widx == 6'd1) en_q <= en_q & ~wmask;
      if (wr_ok && widx == 6'd4) sense_q <= wmask;
      for (int i = 0; i < NUM_IRQ; i++)
        if (wr_ok && widx == 6'(8 + i / 4))
          prio_q[i] <= bus_wdata[8 * (i % 4) +: PRIO_W];
      if (nmi_i && !nmi_q)           nmi_pend_q <= 1'b1;
      else if (ack_i && nmi_pend_q)  nmi_pend_q <= 1'b0;
      if (ack_ext) begin
        act_v_q <= 1'b1;
        act_p_q <= best_p;
      end else if (done_i) begin
        act_v_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_ok) begin
      case (widx)
        6'd0, 6'd1: bus_rdata[NUM_IRQ-1:0] = en_q;
        6'd2, 6'd3: bus_rdata[NUM_IRQ-1:0] = pend_q;
        6'd4:       bus_rdata[NUM_IRQ-1:0] = sense_q;
        default:
          for (int i = 0; i < NUM_IRQ; i++)
            if (widx == 6'(8 + i / 4)) bus_rdata[8 * (i % 4) +: PRIO_W] = prio_q[i];
      endcase
    end
  end
endmodule

// File: rtl/prio_intc_sva.sv
module prio_intc_sva #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               nmi_i,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [1:0]         bus_size,
  input logic [31:0]        bus_rdata,
  input logic               req_valid,
  input logic               req_nmi,
  input logic [ID_W-1:0]    req_id,
  input logic               ack_i,
  input logic               done_i,
  input logic [NUM_IRQ-1:0] en_q,
  input logic [NUM_IRQ-1:0] pend_q,
  input logic [NUM_IRQ-1:0] sense_q,
  input logic [PRIO_W-1:0]  prio_q [NUM_IRQ],
  input logic               act_v_q,
  input logic [PRIO_W-1:0]  act_p_q
);
  a_r9_nmi_taken: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_i) |=> req_valid && req_nmi);
  a_r9_nmi_id: assert property (@(posedge clk) disable iff (!rst_n)
    req_nmi |-> req_valid && req_id == '0);
  a_r7_live_grant: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_nmi |-> en_q[req_id] && pend_q[req_id]);
  a_r8_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_nmi && act_v_q |-> prio_q[req_id] < act_p_q);
  a_r8_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !(ack_i && req_valid && !req_nmi) |=> !act_v_q);
  a_r10_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_wr && bus_size != 2'd2 |=> $stable(en_q) && $stable(sense_q));
  a_r10_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !bus_wr && bus_size != 2'd2 |-> bus_rdata == 32'd0);
endmodule

bind prio_intc prio_intc_sva #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_size(bus_size), .bus_rdata(bus_rdata), .req_valid(req_valid),
  .req_nmi(req_nmi), .req_id(req_id), .ack_i(ack_i), .done_i(done_i),
  .en_q(en_q), .pend_q(pend_q), .sense_q(sense_q), .prio_q(prio_q),
  .act_v_q(act_v_q), .act_p_q(act_p_q)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] irq = '0;
  logic nmi = 0, sel = 0, wr = 0, ack = 0, done = 0;
  logic [1:0] size = 2'd2;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  wire [31:0] rdata;
  wire rv, rn;
  wire [4:0] rid;

  prio_intc dut (.clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .bus_sel(sel),
    .bus_wr(wr), .bus_size(size), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .req_valid(rv), .req_nmi(rn), .req_id(rid), .ack_i(ack), .done_i(done));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  logic [N-1:0] m_en, m_pend, m_sense, m_irqq;
  logic [1:0] m_prio [N];
  logic m_nmiq, m_nmip, m_av;
  logic [1:0] m_ap;

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic void best(output logic f, output logic [4:0] id, output logic [1:0] p);
    f = 0; id = 0; p = 2'd3;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend[i] && (!f || m_prio[i] < p)) begin
        f = 1; id = 5'(i); p = m_prio[i];
      end
  endfunction

  function automatic logic fwd();
    logic f; logic [4:0] id; logic [1:0] p;
    best(f, id, p);
    return f && (!m_av || p < m_ap);
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    if (!(sel && !wr && size == 2'd2 && addr[1:0] == 2'd0)) return '0;
    case (addr[7:2])
      6'd0, 6'd1: r = m_en;
      6'd2, 6'd3: r = m_pend;
      6'd4:       r = m_sense;
      default:
        for (int i = 0; i < N; i++)
          if (int'(addr[7:2]) == 8 + i / 4) r[8 * (i % 4) +: 2] = m_prio[i];
    endcase
    return r;
  endfunction

  task automatic chk_out();
    logic f; logic [4:0] id; logic [1:0] p; logic fw;
    logic [6:0] e;
    best(f, id, p);
    fw = fwd();
    e = {m_nmip | fw, m_nmip, (!m_nmip && fw) ? id : 5'd0};
    check({rv, rn, rid} == e, tag, 32'({rv, rn, rid}), 32'(e));
  endtask

  task automatic model_reset();
    m_en = '0; m_pend = '0; m_sense = '0; m_irqq = '0;
    m_nmiq = 0; m_nmip = 0; m_av = 0; m_ap = '0;
    for (int i = 0; i < N; i++) m_prio[i] = '0;
  endtask

  task automatic tick();
    logic f; logic [4:0] id; logic [1:0] p; logic fw, w, ackext;
    logic [N-1:0] setm, clrm, npend, nen, nsense;
    logic [1:0] nprio [N];
    logic nnmip, nav; logic [1:0] nap;
    best(f, id, p);
    fw = fwd();
    w = sel && wr && size == 2'd2 && addr[1:0] == 2'd0;
    ackext = ack && fw && !m_nmip;
    setm = (~m_sense & irq) | (m_sense & irq & ~m_irqq) | ((w && addr[7:2] == 6'd2) ? wdata : '0);
    clrm = (ackext ? (32'd1 << id) : '0) | ((w && addr[7:2] == 6'd3) ? wdata : '0);
    npend = (m_pend & ~clrm) | setm;
    nen = m_en; nsense = m_sense;
    if (w && addr[7:2] == 6'd0) nen = m_en | wdata;
    if (w && addr[7:2] == 6'd1) nen = m_en & ~wdata;
    if (w && addr[7:2] == 6'd4) nsense = wdata;
    for (int i = 0; i < N; i++)
      nprio[i] = (w && int'(addr[7:2]) == 8 + i / 4) ? wdata[8 * (i % 4) +: 2] : m_prio[i];
    nnmip = m_nmip;
    if (nmi && !m_nmiq) nnmip = 1;
    else if (ack && m_nmip) nnmip = 0;
    nav = m_av; nap = m_ap;
    if (ackext) begin nav = 1; nap = p; end
    else if (done) nav = 0;
    @(negedge clk);
    m_pend = npend; m_en = nen; m_sense = nsense; m_nmip = nnmip;
    m_av = nav; m_ap = nap; m_irqq = irq; m_nmiq = nmi;
    for (int i = 0; i < N; i++) m_prio[i] = nprio[i];
    chk_out();
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s = 2'd2);
    sel = 1; wr = 1; addr = a; wdata = d; size = s;
    tick();
    sel = 0; wr = 0; size = 2'd2;
  endtask

  task automatic bread(input logic [7:0] a, input logic [1:0] s = 2'd2);
    sel = 1; wr = 0; addr = a; size = s;
    #1;
    check(rdata == exp_rd(), tag, rdata, exp_rd());
    tick();
    sel = 0; size = 2'd2;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1 reset state"; chk_out();
    bread(8'h00); bread(8'h08); bread(8'h10); bread(8'h20);

    tag = "R2 enable set/clear";
    bwrite(8'h00, 32'h0000_0FF1); bread(8'h00);
    bwrite(8'h04, 32'h0000_0300); bread(8'h04);

    tag = "R6 priority layout";
    bwrite(8'h24, 32'hFF03_0201); bread(8'h24);
    bwrite(8'h20, 32'hFFFF_FFFF); bread(8'h20); bread(8'h80);

    tag = "R11 disabled pending";
    bwrite(8'h04, 32'h1); bwrite(8'h08, 32'h1); bread(8'h08); idle(2);
    bwrite(8'h00, 32'h1); idle(1);

    tag = "R7 lowest value wins";
    bwrite(8'h08, 32'h0000_00F0); idle(1);
    tag = "R7 tie lower number";
    bwrite(8'h0C, 32'h0000_0030); idle(1);

    tag = "R3 pending set/clear";
    bread(8'h08);
    sel = 1; wr = 1; addr = 8'h08; wdata = 32'h0000_0400; tick();
    addr = 8'h0C; tick(); sel = 0; wr = 0;
    bwrite(8'h0C, 32'hFFFF_FFFF); bread(8'h0C);

    tag = "R8 active threshold";
    bwrite(8'h08, 32'h0000_0040); pulse_ack();
    bwrite(8'h08, 32'h0000_0080); idle(1);
    bwrite(8'h08, 32'h0000_0040); idle(1);
    bwrite(8'h00, 32'h0000_0200); bwrite(8'h08, 32'h0000_0100); idle(1);
    bwrite(8'h00, 32'h0000_0100); idle(1);
    done = 1; ack = 1; tick(); ack = 0; done = 0; idle(1);
    done = 1; tick(); done = 0; idle(1);

    tag = "R5 pulse sensing";
    bwrite(8'h0C, 32'hFFFF_FFFF); bwrite(8'h10, 32'h0000_0200);
    irq[9] = 1; tick(); irq[9] = 0; idle(2); bread(8'h08);
    done = 1; tick(); done = 0;
    while (rv) begin done = 1; ack = 1; tick(); ack = 0; done = 0; end
    irq[9] = 1; tick(); pulse_ack(); idle(2); bread(8'h08); irq[9] = 0;

    tag = "R4 level sensing";
    bwrite(8'h0C, 32'hFFFF_FFFF); done = 1; tick(); done = 0;
    bwrite(8'h00, 32'h0000_0400);
    irq[10] = 1; idle(2); pulse_ack(); bread(8'h08);
    bwrite(8'h0C, 32'h0000_0400); bread(8'h08);
    irq[10] = 0; done = 1; tick(); done = 0; pulse_ack(); bread(8'h08);

    tag = "R9 non-maskable";
    nmi = 1; tick(); idle(1); pulse_ack(); idle(2); nmi = 0; idle(1);
    bwrite(8'h04, 32'hFFFF_FFFF); nmi = 1; tick(); nmi = 0; idle(1); pulse_ack();

    tag = "R10 narrow access";
    bwrite(8'h00, 32'hFFFF_FFFF, 2'd0); bwrite(8'h00, 32'hFFFF_FFFF, 2'd1);
    bwrite(8'h01, 32'hFFFF_FFFF); bread(8'h00);
    bwrite(8'h00, 32'h0000_FFFF); bread(8'h00, 2'd1); bread(8'h00, 2'd0); bread(8'h02);

    tag = "R7 R8 R4 R5 random";
    void'($urandom(32'h1234_5678));
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) irq[$urandom_range(0, N - 1)] ^= 1'b1;
      nmi  = ($urandom_range(0, 40) == 0) ? ~nmi : nmi;
      ack  = rv && ($urandom_range(0, 2) == 0);
      done = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) begin
        logic [7:0] opts [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h3C, 8'h80};
        sel = 1; wr = $urandom_range(0, 1);
        addr = ($urandom_range(0, 3) == 0) ? 8'(32 + 4 * $urandom_range(0, 7)) : opts[$urandom_range(0, 7)];
        size = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 1)) : 2'd2;
        wdata = (addr == 8'h04 || addr == 8'h0C) ? ($urandom & $urandom) : $urandom;
        if (!wr) begin #1; check(rdata == exp_rd(), tag, rdata, exp_rd()); end
      end else begin
        sel = 0; wr = 0; size = 2'd2;
      end
      tick();
    end
    sel = 0; ack = 0; done = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule